// File: doc/BRIEF.md
# Length-Identifying Three-Wire Control Receiver

This block is the serial control front end of a frequency-synthesizer controller. A host drives three lines: an enable that frames a word, a serial clock, and a data line. Bits are taken most significant first on each rising serial clock edge while enable is high. When enable falls, the block counts the bits it received. That count alone decides how the word is laid out and, for the two shorter formats, which reference division ratio applies.

Three lengths are accepted: 18, 19 and 27 bits. Every accepted word sets four output port latches and the programmable-divider word. The 27-bit word also sets a charge-pump current bit, three test bits and a two-bit reference selection. Any other length is dropped without touching a register, and the block raises an error pulse instead. All three serial lines are synchronised into the system clock domain. All fields of one word are committed in a single system clock cycle.

Top module: `tw_ctrl_rx`

## Requirements
- R1: After reset, portOut, divWord, cpHigh and testBits are 0, refRatio is 64, and loadPulse and errPulse are low.
- R2: Serial clock edges while enable is low shift nothing, produce no pulse and change no output.
- R3: An 18-bit word puts its first 4 bits on portOut (first bit on portOut[3]) and its remaining 14 bits on divWord[13:0] with divWord[14]=0, and sets refRatio to 64.
- R4: A 19-bit word puts its first 4 bits on portOut and its remaining 15 bits on divWord, and sets refRatio to 128.
- R5: A 27-bit word is laid out, in transmission order, as 4 port bits, 15 divider bits, cpHigh, testBits[2:0], select bit A, select bit B, then 2 reserved bits that are ignored.
- R6: In a 27-bit word, the select bits {A,B} set refRatio as follows: 00 gives 80, 01 gives 128, 10 gives 64 and 11 gives 64.
- R7: 18-bit and 19-bit words leave cpHigh and testBits unchanged.
- R8: A word of any other length, including 0 bits, changes no output. It raises errPulse for exactly one cycle and does not raise loadPulse.
- R9: The bit count saturates at 31, so a 59-bit word is rejected and is not treated as a 27-bit word.
- R10: An accepted word raises loadPulse for exactly one cycle, in the same cycle its fields appear on the outputs. loadPulse and errPulse are never high together.
- R11: A serial clock rise that reaches the block in the same system cycle as the enable rise is counted as the first bit of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock, asynchronous |
| serData | input | 1 | Serial data, most significant bit first |
| serEn | input | 1 | Frame enable, high for the whole word |
| portOut | output | 4 | Output port latches |
| divWord | output | 15 | Programmable-divider word |
| refRatio | output | 8 | Selected reference division ratio (64, 80 or 128) |
| cpHigh | output | 1 | Charge-pump current select |
| testBits | output | 3 | Test-mode bits |
| loadPulse | output | 1 | One-cycle strobe on an accepted word |
| errPulse | output | 1 | One-cycle strobe on a rejected word |

## Verification
Two events can meet in one system cycle: the rise of enable, which clears the bit counter, and a rise of the serial clock, which increments it. The bench raises serEn and serClk on the same system edge, so both leave the synchronisers together. It then sends an 18-bit word whose first bit comes only from that coincident edge. If that first bit is lost, the count comes out as 17 and the word is rejected. The check therefore passes only if loadPulse rises and the decoded fields match a model in which that first bit was counted.

// File: rtl/twrx_pkg.sv
package twrx_pkg;
  localparam int PORT_W    = 4;
  localparam int LEN_SHORT = 18;
  localparam int LEN_MID   = 19;
  localparam int LEN_LONG  = 27;
  localparam int DIV_W     = LEN_MID - PORT_W;
  localparam int TEST_W    = 3;
  localparam int RATIO_W   = 8;
  localparam int CNT_W     = 5;

  localparam logic [RATIO_W-1:0] RATIO_64  = RATIO_W'(64);
  localparam logic [RATIO_W-1:0] RATIO_80  = RATIO_W'(80);
  localparam logic [RATIO_W-1:0] RATIO_128 = RATIO_W'(128);

  typedef struct packed {
    logic loadShort;
    logic loadMid;
    logic loadLong;
    logic reject;
  } frameStb_t;

  function automatic logic [RATIO_W-1:0] ratioFromSel(input logic [1:0] sel);
    case (sel)
      2'b00:   return RATIO_80;
      2'b01:   return RATIO_128;
      default: return RATIO_64;
    endcase
  endfunction
endpackage

// File: rtl/twrx_ctrl.sv
module twrx_ctrl
  import twrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      serClk,
  input  logic      serData,
  input  logic      serEn,
  output logic      bitIn,
  output logic      shiftEn,
  output frameStb_t stb
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] clkPipe, enPipe, datPipe;
  logic prevClk, prevEn;
  logic syncClk, syncEn;
  logic clkRise, enRise, enFall;
  logic [CNT_W-1:0] bitCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      enPipe  <= '0;
      datPipe <= '0;
      prevClk <= 1'b0;
      prevEn  <= 1'b0;
    end else begin
      clkPipe <= {clkPipe[SYNC_STAGES-2:0], serClk};
      enPipe  <= {enPipe[SYNC_STAGES-2:0], serEn};
      datPipe <= {datPipe[SYNC_STAGES-2:0], serData};
      prevClk <= syncClk;
      prevEn  <= syncEn;
    end
  end

  assign syncClk = clkPipe[SYNC_STAGES-1];
  assign syncEn  = enPipe[SYNC_STAGES-1];
  assign bitIn   = datPipe[SYNC_STAGES-1];
  assign clkRise = syncClk & ~prevClk;
  assign enRise  = syncEn & ~prevEn;
  assign enFall  = ~syncEn & prevEn;
  assign shiftEn = clkRise & syncEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (enRise) begin
      bitCount <= clkRise ? CNT_W'(1) : '0;
    end else if (shiftEn && bitCount != CNT_MAX) begin
      bitCount <= bitCount + CNT_W'(1);
    end
  end

  always_comb begin
    stb = '0;
    if (enFall) begin
      case (bitCount)
        CNT_W'(LEN_SHORT): stb.loadShort = 1'b1;
        CNT_W'(LEN_MID):   stb.loadMid   = 1'b1;
        CNT_W'(LEN_LONG):  stb.loadLong  = 1'b1;
        default:           stb.reject    = 1'b1;
      endcase
    end
  end

  assert_idle_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    !syncEn |=> $stable(bitCount));
  assert_count_sat_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bitCount == CNT_MAX && !enRise) |=> bitCount == CNT_MAX);
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));
endmodule

// File: rtl/twrx_dp.sv
module twrx_dp
  import twrx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitIn,
  input  logic               shiftEn,
  input  frameStb_t          stb,
  output logic [PORT_W-1:0]  portOut,
  output logic [DIV_W-1:0]   divWord,
  output logic [RATIO_W-1:0] refRatio,
  output logic               cpHigh,
  output logic [TEST_W-1:0]  testBits,
  output logic               loadPulse,
  output logic               errPulse
);
  localparam int SHORT_DIV = LEN_SHORT - PORT_W;
  localparam int LONG_DIV_TOP = LEN_LONG - PORT_W - 1;
  localparam int CP_POS = LONG_DIV_TOP - DIV_W;
  localparam int TEST_TOP = CP_POS - 1;
  localparam int SEL_TOP = TEST_TOP - TEST_W;

  logic [LEN_LONG-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (shiftEn) shiftReg <= {shiftReg[LEN_LONG-2:0], bitIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portOut   <= '0;
      divWord   <= '0;
      refRatio  <= RATIO_64;
      cpHigh    <= 1'b0;
      testBits  <= '0;
      loadPulse <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      loadPulse <= stb.loadShort | stb.loadMid | stb.loadLong;
      errPulse  <= stb.reject;
      if (stb.loadShort) begin
        portOut  <= shiftReg[LEN_SHORT-1 -: PORT_W];
        divWord  <= DIV_W'(shiftReg[SHORT_DIV-1:0]);
        refRatio <= RATIO_64;
      end else if (stb.loadMid) begin
        portOut  <= shiftReg[LEN_MID-1 -: PORT_W];
        divWord  <= shiftReg[DIV_W-1:0];
        refRatio <= RATIO_128;
      end else if (stb.loadLong) begin
        portOut  <= shiftReg[LEN_LONG-1 -: PORT_W];
        divWord  <= shiftReg[LONG_DIV_TOP -: DIV_W];
        cpHigh   <= shiftReg[CP_POS];
        testBits <= shiftReg[TEST_TOP -: TEST_W];
        refRatio <= ratioFromSel(shiftReg[SEL_TOP -: 2]);
      end
    end
  end

  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(loadPulse && errPulse));
  assert_load_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |=> !loadPulse);
  assert_err_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);
  assert_err_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> ($stable(portOut) && $stable(divWord) && $stable(refRatio)
                  && $stable(cpHigh) && $stable(testBits)));
  assert_ratio_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    refRatio == RATIO_64 || refRatio == RATIO_80 || refRatio == RATIO_128);
endmodule

// File: rtl/tw_ctrl_rx.sv
module tw_ctrl_rx
  import twrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClk,
  input  logic               serData,
  input  logic               serEn,
  output logic [PORT_W-1:0]  portOut,
  output logic [DIV_W-1:0]   divWord,
  output logic [RATIO_W-1:0] refRatio,
  output logic               cpHigh,
  output logic [TEST_W-1:0]  testBits,
  output logic               loadPulse,
  output logic               errPulse
);
  logic      bitIn;
  logic      shiftEn;
  frameStb_t stb;

  twrx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serEn(serEn),
    .bitIn(bitIn), .shiftEn(shiftEn), .stb(stb)
  );

  twrx_dp dp_i (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .shiftEn(shiftEn), .stb(stb),
    .portOut(portOut), .divWord(divWord), .refRatio(refRatio), .cpHigh(cpHigh),
    .testBits(testBits), .loadPulse(loadPulse), .errPulse(errPulse)
  );
endmodule

// File: tb/tw_ctrl_rx_tb.sv
module tw_ctrl_rx_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serEn = 1'b0;
  logic [3:0]  portOut;
  logic [14:0] divWord;
  logic [7:0]  refRatio;
  logic        cpHigh;
  logic [2:0]  testBits;
  logic        loadPulse, errPulse;

  int nChecks = 0, nFails = 0;
  int loadSeen, errSeen;
  logic [3:0]  expPorts = '0;
  logic [14:0] expDiv = '0;
  logic [7:0]  expRatio = 8'd64;
  logic        expCp = 1'b0;
  logic [2:0]  expTest = '0;
  bit finished = 0;

  always #5ns clk = ~clk;

  tw_ctrl_rx dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serEn(serEn),
    .portOut(portOut), .divWord(divWord), .refRatio(refRatio), .cpHigh(cpHigh),
    .testBits(testBits), .loadPulse(loadPulse), .errPulse(errPulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] selRatio(input logic [1:0] s);
    return (s == 2'b00) ? 8'd80 : (s == 2'b01) ? 8'd128 : 8'd64;
  endfunction

  function automatic bit isValid(input int len);
    return len == 18 || len == 19 || len == 27;
  endfunction

  task automatic applyModel(input logic [63:0] w, input int len);
    if (len == 18) begin
      expPorts = w[17:14]; expDiv = {1'b0, w[13:0]}; expRatio = 8'd64;
    end else if (len == 19) begin
      expPorts = w[18:15]; expDiv = w[14:0]; expRatio = 8'd128;
    end else if (len == 27) begin
      expPorts = w[26:23]; expDiv = w[22:8]; expCp = w[7];
      expTest = w[6:4]; expRatio = selRatio(w[3:2]);
    end
  endtask

  task automatic observe();
    loadSeen = 0; errSeen = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (loadPulse) loadSeen++;
      if (errPulse) errSeen++;
    end
  endtask

  task automatic sendFrame(input logic [63:0] w, input int len, input bit simul);
    int start;
    start = len - 1;
    if (simul) begin
      serData = w[len-1];
      repeat (4) @(negedge clk);
      serEn = 1'b1; serClk = 1'b1;
      repeat (4) @(negedge clk);
      serClk = 1'b0;
      start = len - 2;
    end else begin
      serEn = 1'b1;
    end
    repeat (4) @(negedge clk);
    for (int i = start; i >= 0; i--) begin
      serData = w[i];
      repeat (4) @(negedge clk);
      serClk = 1'b1;
      repeat (4) @(negedge clk);
      serClk = 1'b0;
    end
    repeat (2) @(negedge clk);
    serEn = 1'b0;
    observe();
  endtask

  task automatic checkOutputs(input int len);
    string tp, tr, tc;
    tp = (len == 18) ? "R3" : (len == 19) ? "R4" : (len == 27) ? "R5" : (len == 59) ? "R9" : "R8";
    tr = (len == 27) ? "R6" : tp;
    tc = (len == 18 || len == 19) ? "R7" : tp;
    check(portOut == expPorts, {tp, " ports"}, portOut, expPorts);
    check(divWord == expDiv, {tp, " divider"}, divWord, expDiv);
    check(refRatio == expRatio, {tr, " ratio"}, refRatio, expRatio);
    check(cpHigh == expCp, {tc, " charge pump"}, cpHigh, expCp);
    check(testBits == expTest, {tc, " test bits"}, testBits, expTest);
  endtask

  task automatic runFrame(input logic [63:0] w, input int len, input bit simul);
    sendFrame(w, len, simul);
    if (isValid(len)) begin
      applyModel(w, len);
      check(loadSeen == 1, simul ? "R11 load pulse" : "R10 load pulse count", loadSeen, 1);
      check(errSeen == 0, "R10 no error on valid", errSeen, 0);
    end else begin
      check(errSeen == 1, (len == 59) ? "R9 error pulse" : "R8 error pulse count", errSeen, 1);
      check(loadSeen == 0, "R8 no load on invalid", loadSeen, 0);
    end
    checkOutputs(len);
  endtask

  initial begin
    #1500us;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [63:0] w;
    int len, r;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(portOut == 0 && divWord == 0, "R1 ports/divider", divWord, 0);
    check(refRatio == 8'd64, "R1 ratio", refRatio, 64);
    check(cpHigh == 0 && testBits == 0, "R1 cp/test", testBits, 0);
    check(!loadPulse && !errPulse, "R1 pulses", loadPulse, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 clocks with enable low
    for (int i = 0; i < 6; i++) begin
      serData = i[0];
      repeat (3) @(negedge clk); serClk = 1'b1;
      repeat (3) @(negedge clk); serClk = 1'b0;
    end
    observe();
    check(loadSeen == 0 && errSeen == 0, "R2 no pulse while idle", loadSeen + errSeen, 0);
    checkOutputs(0);

    runFrame(64'h2_B5A3, 18, 0);             // R3
    runFrame(64'h5_4C71, 19, 0);             // R4
    runFrame(64'h5A5_A5F0, 27, 0);           // R5 sel 00 -> R6
    runFrame(64'h3C3_C3B4, 27, 0);           // sel 01
    runFrame(64'h123_4568, 27, 0);           // sel 10
    runFrame(64'h7FF_FFFF, 27, 0);           // sel 11
    runFrame(64'h1_0001, 18, 0);             // R7 cp/test kept
    runFrame(64'h1_FFFF, 17, 0);             // R8
    runFrame(64'hFFF_FFFF, 28, 0);           // R8
    runFrame(64'h0, 0, 0);                   // R8 empty frame
    runFrame(64'h7ABC_DEF0_1234_5678, 59, 0); // R9
    runFrame(64'h3_9D2E, 18, 1);             // R11

    for (int n = 0; n < 40; n++) begin
      r = $urandom % 4;
      w = {$urandom, $urandom};
      if (r == 0) len = 18;
      else if (r == 1) len = 19;
      else if (r == 2) len = 27;
      else begin
        len = $urandom % 40;
        if (isValid(len)) len = len + 2;
      end
      runFrame(w, len, ($urandom % 5) == 0 && len > 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule